// File: doc/BRIEF.md
# Latched Event Status Register with Maskable Interrupt

This block collects up to eight event lines from a neighbouring controller and makes them visible to a host as one status word. Each bit position is built either as a sticky bit or as a live bit, and a parameter chooses which. A sticky bit records that its event line rose, and it keeps that record until the host writes a 1 to that position. A live bit shows its event line as it is right now. It keeps no history and ignores host writes.

A second word, the enable register, lets the host choose which sticky bits may pull down a shared active-low interrupt line. The line stays low while any enabled sticky bit is set. It goes high again once the host has cleared every such bit. The host can poll the status word, react to the interrupt, or do both.

Top module: `evt_status_reg`

## Requirements
- R1: While reset is low and in the first cycle after it, every sticky status bit and every enable bit reads 0 and `irq_n_o` is 1.
- R2: On a sticky position, a rising edge on `evt_i` (0 in one cycle, 1 in the next) sets that `status_o` bit at the next clock edge. The bit then stays 1 while no clear is written.
- R3: A sticky bit that has been cleared while its event line stays at 1 remains 0 until the line falls and rises again.
- R4: A write with `sts_wr_i` high clears exactly the sticky bits whose `wr_data_i` bit is 1. Sticky bits written with 0 keep their value.
- R5: If a rising edge and a clear of the same sticky bit fall in the same cycle, the bit ends up set.
- R6: A live position (its `LATCH_MASK` bit is 0; the default 8'h3F makes bits 6 and 7 live) shows `evt_i` on `status_o` in the same cycle, and status writes do not affect it.
- R7: A write with `en_wr_i` high loads `wr_data_i` into the enable register at the next edge. `enable_o` shows the register, and enable bits at live positions always read 0.
- R8: `irq_n_o` is 0 exactly when some sticky bit and its enable bit are both 1. Live bits never affect it.
- R9: After the host clears the sticky bit that caused an interrupt, `irq_n_o` returns to 1 only if no other enabled sticky bit is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 8 | Event lines from the controller, one per status bit |
| sts_wr_i | input | 1 | Write strobe for the status word (write-1-to-clear) |
| en_wr_i | input | 1 | Write strobe for the enable register |
| wr_data_i | input | 8 | Host write data |
| status_o | output | 8 | Status word: sticky bits from flops, live bits straight from `evt_i` |
| enable_o | output | 8 | Enable register contents |
| irq_n_o | output | 1 | Interrupt, active low |

## Verification
A rising edge on an event line shows up on `status_o` one edge later, because the edge detector is combinational against a one-flop history and the sticky bit is the only register in the path. Status clears and enable writes also take effect at the next edge. Live bits and `irq_n_o` follow the current flops and inputs in the same cycle, with no extra delay. The bench drives inputs just after the falling edge and then compares every output against its reference model, still before the rising edge. The model advances at each rising edge, so each result is checked in the cycle when it is due.

// File: rtl/esr_pkg.sv
// Package: shared width and vector type for the event status register.
// Assumes one status word per instance; wider words are built from
// several instances.
package esr_pkg;
    localparam int unsigned STS_W = 8;
    typedef logic [STS_W-1:0] sts_vec_t;
endpackage

// File: rtl/esr_edge_detect.sv
// Rising-edge detector, one per event line.
// Assumes lvl_i is already synchronous to clk. The history resets to 0,
// so a line that is high when reset ends counts as a new occurrence.
module esr_edge_detect #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] hist_q;

    for (genvar b = 0; b < W; b++) begin : g_bit
        // keep last cycle's level of line b
        always_ff @(posedge clk) begin
            if (!rst_n) hist_q[b] <= 1'b0;
            else        hist_q[b] <= lvl_i[b];
        end
        // flag a 0->1 transition of line b
        assign rise_o[b] = lvl_i[b] & ~hist_q[b];
    end

    // R3: a reported rise needs the line to have been low the cycle before
    rise_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((rise_o & $past(lvl_i)) == '0) || !$past(rst_n));
endmodule

// File: rtl/esr_status_latch.sv
// Sticky status bits with write-1-to-clear.
// Assumes rise_i is a one-cycle pulse per event occurrence. Positions
// whose LATCH_MASK bit is 0 are held at 0 here; the top fills them
// with live values.
module esr_status_latch #(
    parameter int unsigned      W          = 8,
    parameter logic [W-1:0]     LATCH_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rise_i,
    input  logic         clr_en_i,
    input  logic [W-1:0] clr_data_i,
    output logic [W-1:0] sticky_o
);
    logic [W-1:0] sticky_q;
    logic [W-1:0] clr_vec;

    // bits the host asks to clear this cycle
    assign clr_vec = clr_en_i ? clr_data_i : '0;

    // set on a new edge, clear on write-1; a new edge wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n) sticky_q <= '0;
        else        sticky_q <= ((sticky_q & ~clr_vec) | rise_i) & LATCH_MASK;
    end

    assign sticky_o = sticky_q;

    // R2: every sticky position that saw an edge is set one cycle later
    set_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky_q & $past(rise_i & LATCH_MASK)) == $past(rise_i & LATCH_MASK)));

    // R4: bits not written with 1 keep a 1
    keep_unwritten_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky_q & $past(sticky_q & ~clr_vec)) == $past(sticky_q & ~clr_vec)));

    // R4: bits written with 1 and without a new edge end up 0
    clear_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en_i |=> ((sticky_q & $past(clr_data_i & ~rise_i)) == '0));

    // R3: no bit goes from 0 to 1 without an edge
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sticky_q & ~$past(sticky_q) & ~$past(rise_i)) == '0));
endmodule

// File: rtl/esr_irq_gen.sv
// Enable register and active-low interrupt.
// Assumes sticky_i is already zero at live positions; LATCH_MASK is
// applied again to the enable bits so live positions can never enable.
module esr_irq_gen #(
    parameter int unsigned      W          = 8,
    parameter logic [W-1:0]     LATCH_MASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_wr_i,
    input  logic [W-1:0] wr_data_i,
    input  logic [W-1:0] sticky_i,
    output logic [W-1:0] enable_o,
    output logic         irq_n_o
);
    logic [W-1:0] en_q;
    logic [W-1:0] pending;

    // load the enable register from the host
    always_ff @(posedge clk) begin
        if (!rst_n)       en_q <= '0;
        else if (en_wr_i) en_q <= wr_data_i & LATCH_MASK;
    end

    // enabled events that are still set
    assign pending  = sticky_i & en_q;
    assign enable_o = en_q;
    assign irq_n_o  = ~(|pending);

    // R7: a host write shows up on enable_o at the next edge
    en_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_wr_i |=> (en_q == $past(wr_data_i & LATCH_MASK)));

    // R8: live positions never hold an enable bit
    en_live_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q & ~LATCH_MASK) == '0);
endmodule

// File: rtl/evt_status_reg.sv
// Top: event status word with per-bit sticky or live behaviour and a
// maskable active-low interrupt.
// Assumes evt_i is synchronous to clk. Status reads have no side effect;
// sticky bits are cleared only by write-1.
module evt_status_reg
    import esr_pkg::*;
#(
    parameter logic [STS_W-1:0] LATCH_MASK = 8'h3F
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STS_W-1:0] evt_i,
    input  logic             sts_wr_i,
    input  logic             en_wr_i,
    input  logic [STS_W-1:0] wr_data_i,
    output logic [STS_W-1:0] status_o,
    output logic [STS_W-1:0] enable_o,
    output logic             irq_n_o
);
    sts_vec_t rise;
    sts_vec_t sticky;

    esr_edge_detect #(.W(STS_W)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (evt_i),
        .rise_o (rise)
    );

    esr_status_latch #(.W(STS_W), .LATCH_MASK(LATCH_MASK)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .clr_en_i   (sts_wr_i),
        .clr_data_i (wr_data_i),
        .sticky_o   (sticky)
    );

    esr_irq_gen #(.W(STS_W), .LATCH_MASK(LATCH_MASK)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_wr_i   (en_wr_i),
        .wr_data_i (wr_data_i),
        .sticky_i  (sticky),
        .enable_o  (enable_o),
        .irq_n_o   (irq_n_o)
    );

    // merge sticky flops with live event levels
    assign status_o = sticky | (evt_i & ~LATCH_MASK);

    // R1: the cycle after reset ends, the interrupt is inactive
    irq_idle_after_reset_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> irq_n_o);

    // R8: a low interrupt always has an enabled sticky bit behind it
    irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n_o |-> ((status_o & enable_o & LATCH_MASK) != '0));
endmodule

// File: tb/tb_evt_status_reg.sv
module tb_evt_status_reg;
    localparam int         CLK_PERIOD = 10;
    localparam logic [7:0] LM         = 8'h3F;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] evt_i;
    logic       sts_wr_i;
    logic       en_wr_i;
    logic [7:0] wr_data_i;
    logic [7:0] status_o;
    logic [7:0] enable_o;
    logic       irq_n_o;

    int n_cmp = 0;
    int n_bad = 0;
    string req = "R1";

    // reference state, per bit
    bit m_lat  [8];
    bit m_en   [8];
    bit m_prev [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_status_reg #(.LATCH_MASK(LM)) dut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .sts_wr_i(sts_wr_i),
        .en_wr_i(en_wr_i), .wr_data_i(wr_data_i), .status_o(status_o),
        .enable_o(enable_o), .irq_n_o(irq_n_o)
    );

    task automatic cmp(input string r, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // expected outputs from the current model state and inputs
    task automatic compare_now();
        logic [7:0] e_sts, e_en;
        bit any;
        any = 0;
        for (int i = 0; i < 8; i++) begin
            if (LM[i]) e_sts[i] = m_lat[i];
            else       e_sts[i] = evt_i[i];
            e_en[i] = m_en[i];
            if (LM[i] && m_lat[i] && m_en[i]) any = 1;
        end
        cmp(req, "status", int'(status_o), int'(e_sts));
        cmp(req, "enable", int'(enable_o), int'(e_en));
        cmp(req, "irq_n",  int'(irq_n_o),  int'(!any));
    endtask

    // one cycle: drive after falling edge, compare, advance model at rising edge
    task automatic step(input bit rst, input logic [7:0] ev, input bit sw,
                        input bit ew, input logic [7:0] d);
        @(negedge clk);
        rst_n = rst; evt_i = ev; sts_wr_i = sw; en_wr_i = ew; wr_data_i = d;
        #1;
        compare_now();
        @(posedge clk);
        for (int i = 0; i < 8; i++) begin
            if (!rst) begin
                m_lat[i] = 0; m_en[i] = 0; m_prev[i] = 0;
            end else begin
                bit rise;
                rise = ev[i] && !m_prev[i];
                if (LM[i]) begin
                    if (sw && d[i]) m_lat[i] = 0;
                    if (rise)       m_lat[i] = 1;
                    if (ew)         m_en[i]  = d[i];
                end
                m_prev[i] = ev[i];
            end
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin m_lat[i] = 0; m_en[i] = 0; m_prev[i] = 0; end
        rst_n = 1'b0; evt_i = '0; sts_wr_i = 0; en_wr_i = 0; wr_data_i = '0;
        // R1: reset state and first cycle after reset
        req = "R1";
        repeat (3) step(0, 8'h00, 0, 0, 8'h00);
        step(1, 8'h00, 0, 0, 8'h00);
        // R7: enable write, including live positions that must read 0
        req = "R7";
        step(1, 8'h00, 0, 1, 8'hC5);
        step(1, 8'h00, 0, 0, 8'h00);
        // R2: rising edge on bit 0 sets it and drives the interrupt low (R8)
        req = "R2";
        repeat (4) step(1, 8'h01, 0, 0, 8'h00);
        // R3: clear while the line stays high; no re-set
        req = "R3";
        step(1, 8'h01, 1, 0, 8'h01);
        repeat (4) step(1, 8'h01, 0, 0, 8'h00);
        step(1, 8'h00, 0, 0, 8'h00);
        step(1, 8'h01, 0, 0, 8'h00);
        step(1, 8'h01, 0, 0, 8'h00);
        // R4: partial clear leaves unwritten bits alone
        req = "R4";
        step(1, 8'h0F, 0, 0, 8'h00);
        step(1, 8'h00, 0, 0, 8'h00);
        step(1, 8'h00, 1, 0, 8'h0A);
        step(1, 8'h00, 0, 0, 8'h00);
        step(1, 8'h00, 1, 0, 8'h05);
        step(1, 8'h00, 0, 0, 8'h00);
        // R5: edge and clear of bit 4 in the same cycle
        req = "R5";
        step(1, 8'h10, 0, 0, 8'h00);
        step(1, 8'h00, 0, 0, 8'h00);
        step(1, 8'h10, 1, 0, 8'h10);
        step(1, 8'h10, 0, 0, 8'h00);
        step(1, 8'h00, 1, 0, 8'h10);
        step(1, 8'h00, 0, 0, 8'h00);
        // R6: live bits follow evt_i and ignore status writes
        req = "R6";
        step(1, 8'h40, 0, 0, 8'h00);
        step(1, 8'hC0, 1, 0, 8'hC0);
        step(1, 8'h80, 0, 1, 8'hC0);
        step(1, 8'h00, 1, 0, 8'hFF);
        step(1, 8'hC0, 0, 0, 8'h00);
        step(1, 8'h00, 0, 0, 8'h00);
        // R8: set but disabled bit keeps interrupt high, then enable it
        req = "R8";
        step(1, 8'h20, 0, 0, 8'h00);
        step(1, 8'h00, 0, 0, 8'h00);
        step(1, 8'h00, 0, 1, 8'h20);
        step(1, 8'h00, 0, 0, 8'h00);
        step(1, 8'h00, 0, 1, 8'h00);
        step(1, 8'h00, 0, 0, 8'h00);
        // R9: two enabled pending bits, clear one then the other
        req = "R9";
        step(1, 8'h00, 0, 1, 8'h06);
        step(1, 8'h06, 0, 0, 8'h00);
        step(1, 8'h00, 1, 0, 8'h02);
        step(1, 8'h00, 0, 0, 8'h00);
        step(1, 8'h00, 1, 0, 8'h04);
        step(1, 8'h00, 0, 0, 8'h00);
        // R1: reset in the middle clears state again
        req = "R1";
        step(1, 8'h02, 0, 1, 8'hFF);
        step(1, 8'h00, 0, 0, 8'h00);
        step(0, 8'h00, 0, 0, 8'h00);
        step(1, 8'h00, 0, 0, 8'h00);
        step(1, 8'h00, 0, 0, 8'h00);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule